// File: doc/BRIEF.md
# Credit-Controlled Stream Channel Endpoints

This block carries one process-network channel between a producing task and a consuming task that sit on opposite ends of a packet link. The producer endpoint buffers tokens in a local FIFO and forwards them on a forward link. The consumer endpoint buffers received tokens in its own FIFO and hands them to the consuming task. A reverse link carries flow-control messages back. The producer never sees the remote FIFO directly. Its only knowledge of remote space comes from those messages, so a token is never forwarded into a full consumer FIFO.

Both application sides are valid/ready streams. A read stalls while the consumer FIFO is empty, and a write stalls while the producer FIFO is full. The back-pressure policy is selectable:
- **Credit per token (mode 0):** the consumer returns one credit for every token it pops.
- **Batched credit (mode 1):** the consumer returns one credit message for every n tokens. A partial batch is flushed when its FIFO drains.
- **Pull (mode 2):** the consumer asks for data, stating how much it can take, and the producer answers with a single burst.

A policy change is taken only while the whole channel is quiet.

Top module: `credit_stream_channel`

## Requirements
- R1: Every token accepted on the input stream leaves the output stream exactly once, unchanged and in acceptance order, in every mode.
- R2: `out_vld_o` is low whenever the consumer FIFO is empty. While `out_vld_o` is high and `out_rdy_i` is low, `out_vld_o` and `out_data_o` hold.
- R3: The consumer FIFO never receives a token while full. With the consumer stalled, exactly CDEP+PDEP tokens are accepted, after which `in_rdy_o` stays low.
- R4: In mode 0, each pop causes, one cycle later, one reverse message with `rev_req_o`=0 and `rev_cnt_o`=1. The message counts over a stream sum to the token count.
- R5: In mode 1, a credit message (`rev_req_o`=0) is sent when n pops have accumulated, carrying n. When a pop empties the consumer FIFO with no token arriving, the partial count is sent at once. Every message carries 1..n, and the counts over a stream sum to the token count.
- R6: In mode 2, the consumer sends a request (`rev_req_o`=1) only while it has no request outstanding and has free slots. The request count equals the free slots in the cycle before the message appears. The producer answers with one burst of up to that many tokens, with `fwd_last_o` high on the final token.
- R7: After reset: `in_rdy_o`=1, `out_vld_o`=0, no link traffic, mode 0, n=CDEP, and the producer's credit equals CDEP. Exactly CDEP tokens therefore cross the link to a stalled consumer.
- R8: A configuration write (`cfg_we_i`) is taken only when both FIFOs are empty, all credit is back, no burst is running and both links are quiet. Mode 3, n=0 and n>CDEP are ignored. `mode_o` and `batch_o` show the active setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Requested policy: 0 per token, 1 batched, 2 pull |
| cfg_batch_i | input | CCW | Requested batch size n |
| mode_o | output | 2 | Active policy |
| batch_o | output | CCW | Active batch size |
| in_vld_i | input | 1 | Producer-side token valid |
| in_data_i | input | W | Producer-side token |
| in_rdy_o | output | 1 | Producer FIFO can accept |
| fwd_vld_o | output | 1 | Forward link flit sent by producer |
| fwd_data_o | output | W | Forward link token |
| fwd_last_o | output | 1 | Last token of a packet |
| fwd_vld_i | input | 1 | Forward link flit arriving at consumer |
| fwd_data_i | input | W | Arriving token |
| fwd_last_i | input | 1 | Arriving last-of-packet flag |
| rev_vld_o | output | 1 | Reverse message sent by consumer |
| rev_req_o | output | 1 | 1 request, 0 credit |
| rev_cnt_o | output | CCW | Credit count or request size |
| rev_vld_i | input | 1 | Reverse message arriving at producer |
| rev_req_i | input | 1 | Arriving message kind |
| rev_cnt_i | input | CCW | Arriving count |
| out_vld_o | output | 1 | Consumer-side token valid |
| out_data_o | output | W | Consumer-side token |
| out_rdy_i | input | 1 | Consuming task ready |

## Verification
Two cases are hard to reach from the ports, because each needs a particular alignment of arrivals and pops:
- A partial batch flushed on drain.
- A pull burst that is shorter than the request, because the producer holds fewer tokens than were asked for.

The stimulus sweeps every batch size against several ready/valid duty patterns, including a slow consumer that drains its FIFO between arrivals and a bursty producer. A monitor then checks each short credit message against an empty output. It also checks each request count against the occupancy it tracks from the link and pop handshakes.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [1:0] {
    MODE_TOKEN = 2'd0,
    MODE_BATCH = 2'd1,
    MODE_PULL  = 2'd2
  } mode_e;
endpackage

// File: rtl/csc_fifo.sv
module csc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign cnt_o   = cnt_q;
  assign dout_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_FIFO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)) else $error("fifo count out of range"); // R3
endmodule

// File: rtl/csc_producer.sv
module csc_producer
  import csc_pkg::*;
#(
  parameter int W    = 8,
  parameter int PDEP = 4,
  parameter int CDEP = 4,
  localparam int PCW = $clog2(PDEP + 1),
  localparam int CCW = $clog2(CDEP + 1),
  localparam int MW  = (PCW > CCW) ? PCW : CCW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     mode_i,
  input  logic           cfg_clr_i,
  input  logic           in_vld_i,
  input  logic [W-1:0]   in_data_i,
  output logic           in_rdy_o,
  output logic           fwd_vld_o,
  output logic [W-1:0]   fwd_data_o,
  output logic           fwd_last_o,
  input  logic           rev_vld_i,
  input  logic           rev_req_i,
  input  logic [CCW-1:0] rev_cnt_i,
  output logic           idle_o
);
  logic           f_empty, f_full;
  logic [PCW-1:0] f_cnt;
  logic [CCW-1:0] cred_q, gain;
  logic           pend_q, busy_q;
  logic [MW-1:0]  cap_q, left_q, held, blen, left_now;
  logic           is_pull, start, send_pull, send_cred, send;

  csc_fifo #(.W(W), .DEPTH(PDEP)) u_buf (
    .clk_i, .rst_ni,
    .push_i (in_vld_i && !f_full),
    .din_i  (in_data_i),
    .pop_i  (send),
    .dout_o (fwd_data_o),
    .empty_o(f_empty),
    .full_o (f_full),
    .cnt_o  (f_cnt)
  );

  assign in_rdy_o  = !f_full;
  assign is_pull   = (mode_i == MODE_PULL);
  assign held      = MW'(f_cnt);
  assign blen      = (held < cap_q) ? held : cap_q;
  assign start     = is_pull && pend_q && !busy_q && !f_empty;
  assign left_now  = start ? blen : left_q;
  assign send_pull = is_pull && (start || busy_q);
  assign send_cred = !is_pull && !f_empty && (cred_q != '0);
  assign send      = send_pull || send_cred;
  assign gain      = (rev_vld_i && !rev_req_i) ? rev_cnt_i : '0;

  assign fwd_vld_o  = send;
  assign fwd_last_o = is_pull ? (left_now == MW'(1)) : 1'b1;
  assign idle_o     = f_empty && (cred_q == CCW'(CDEP)) && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cred_q <= CCW'(CDEP);
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      cap_q  <= '0;
      left_q <= '0;
    end else begin
      cred_q <= cred_q - CCW'(send_cred) + gain;
      if (cfg_clr_i) begin
        pend_q <= 1'b0;
      end else if (rev_vld_i && rev_req_i) begin
        pend_q <= 1'b1;
        cap_q  <= MW'(rev_cnt_i);
      end else if (start) begin
        pend_q <= 1'b0;
      end
      if (send_pull) begin
        left_q <= left_now - MW'(1);
        busy_q <= (left_now != MW'(1));
      end
    end
  end

  AST_CRED_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cred_q <= CCW'(CDEP)) else $error("credit above remote depth"); // R7
  AST_BURST_FED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !f_empty) else $error("burst ran dry"); // R6
endmodule

// File: rtl/csc_consumer.sv
module csc_consumer
  import csc_pkg::*;
#(
  parameter int W    = 8,
  parameter int CDEP = 4,
  localparam int CCW = $clog2(CDEP + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     mode_i,
  input  logic [CCW-1:0] batch_i,
  input  logic           cfg_clr_i,
  input  logic           fwd_vld_i,
  input  logic [W-1:0]   fwd_data_i,
  input  logic           fwd_last_i,
  output logic           out_vld_o,
  output logic [W-1:0]   out_data_o,
  input  logic           out_rdy_i,
  output logic           rev_vld_o,
  output logic           rev_req_o,
  output logic [CCW-1:0] rev_cnt_o,
  output logic           idle_o
);
  logic           c_empty, c_full, pop, drain;
  logic [CCW-1:0] c_cnt, free, acc_q, acc_d, acc_n, snd_cnt;
  logic           outst_q, outst_d, snd, snd_req;
  logic           rv_q, rq_q;
  logic [CCW-1:0] rc_q;
  logic [CCW-1:0] lim_q, got_q;

  csc_fifo #(.W(W), .DEPTH(CDEP)) u_buf (
    .clk_i, .rst_ni,
    .push_i (fwd_vld_i),
    .din_i  (fwd_data_i),
    .pop_i  (pop),
    .dout_o (out_data_o),
    .empty_o(c_empty),
    .full_o (c_full),
    .cnt_o  (c_cnt)
  );

  assign out_vld_o = !c_empty;
  assign pop       = out_rdy_i && !c_empty;
  assign free      = CCW'(CDEP) - c_cnt;
  assign drain     = pop && !fwd_vld_i && (c_cnt == CCW'(1));
  assign acc_n     = acc_q + CCW'(1);

  always_comb begin
    snd     = 1'b0;
    snd_req = 1'b0;
    snd_cnt = '0;
    acc_d   = acc_q;
    outst_d = outst_q;
    if (fwd_vld_i && fwd_last_i) outst_d = 1'b0;
    case (mode_i)
      MODE_TOKEN: if (pop) begin
        snd     = 1'b1;
        snd_cnt = CCW'(1);
      end
      MODE_BATCH: if (pop) begin
        if (acc_n == batch_i || drain) begin
          snd     = 1'b1;
          snd_cnt = acc_n;
          acc_d   = '0;
        end else begin
          acc_d = acc_n;
        end
      end
      MODE_PULL: if (!outst_q && free != '0) begin
        snd     = 1'b1;
        snd_req = 1'b1;
        snd_cnt = free;
        outst_d = 1'b1;
      end
      default: ;
    endcase
    if (cfg_clr_i) begin
      snd     = 1'b0;
      acc_d   = '0;
      outst_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      outst_q <= 1'b0;
      rv_q    <= 1'b0;
      rq_q    <= 1'b0;
      rc_q    <= '0;
      lim_q   <= '0;
      got_q   <= '0;
    end else begin
      acc_q   <= acc_d;
      outst_q <= outst_d;
      rv_q    <= snd;
      rq_q    <= snd_req;
      rc_q    <= snd_cnt;
      if (snd && snd_req) begin
        lim_q <= snd_cnt;
        got_q <= '0;
      end else if (fwd_vld_i) begin
        got_q <= got_q + CCW'(1);
      end
    end
  end

  assign rev_vld_o = rv_q;
  assign rev_req_o = rq_q;
  assign rev_cnt_o = rc_q;
  assign idle_o    = c_empty && (acc_q == '0) && !rv_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_vld_i |-> !c_full) else $error("token into full fifo"); // R3
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o && !out_rdy_i |=> out_vld_o && $stable(out_data_o)) else $error("stalled output moved"); // R2
  AST_TOKEN_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_vld_o && mode_i == MODE_TOKEN |-> !rev_req_o && rev_cnt_o == CCW'(1)) else $error("bad token credit"); // R4
  AST_BATCH_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rev_vld_o && mode_i == MODE_BATCH |-> rev_cnt_o != '0 && rev_cnt_o <= batch_i) else $error("bad batch credit"); // R5
  AST_BURST_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_vld_i && mode_i == MODE_PULL |-> got_q < lim_q) else $error("burst above request"); // R6
endmodule

// File: rtl/credit_stream_channel.sv
module credit_stream_channel
  import csc_pkg::*;
#(
  parameter int W    = 8,
  parameter int PDEP = 4,
  parameter int CDEP = 4,
  localparam int CCW = $clog2(CDEP + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [1:0]     cfg_mode_i,
  input  logic [CCW-1:0] cfg_batch_i,
  output logic [1:0]     mode_o,
  output logic [CCW-1:0] batch_o,
  input  logic           in_vld_i,
  input  logic [W-1:0]   in_data_i,
  output logic           in_rdy_o,
  output logic           fwd_vld_o,
  output logic [W-1:0]   fwd_data_o,
  output logic           fwd_last_o,
  input  logic           fwd_vld_i,
  input  logic [W-1:0]   fwd_data_i,
  input  logic           fwd_last_i,
  output logic           rev_vld_o,
  output logic           rev_req_o,
  output logic [CCW-1:0] rev_cnt_o,
  input  logic           rev_vld_i,
  input  logic           rev_req_i,
  input  logic [CCW-1:0] rev_cnt_i,
  output logic           out_vld_o,
  output logic [W-1:0]   out_data_o,
  input  logic           out_rdy_i
);
  mode_e          mode_q;
  logic [CCW-1:0] batch_q;
  logic           p_idle, c_idle, quiet, cfg_ok;

  assign quiet  = p_idle && c_idle && !fwd_vld_i && !rev_vld_i;
  assign cfg_ok = cfg_we_i && quiet && (cfg_mode_i != 2'd3) &&
                  (cfg_batch_i != '0) && (cfg_batch_i <= CCW'(CDEP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_TOKEN;
      batch_q <= CCW'(CDEP);
    end else if (cfg_ok) begin
      mode_q  <= mode_e'(cfg_mode_i);
      batch_q <= cfg_batch_i;
    end
  end

  assign mode_o  = mode_q;
  assign batch_o = batch_q;

  csc_producer #(.W(W), .PDEP(PDEP), .CDEP(CDEP)) u_prod (
    .clk_i, .rst_ni,
    .mode_i    (mode_q),
    .cfg_clr_i (cfg_ok),
    .in_vld_i, .in_data_i, .in_rdy_o,
    .fwd_vld_o, .fwd_data_o, .fwd_last_o,
    .rev_vld_i, .rev_req_i, .rev_cnt_i,
    .idle_o    (p_idle)
  );

  csc_consumer #(.W(W), .CDEP(CDEP)) u_cons (
    .clk_i, .rst_ni,
    .mode_i    (mode_q),
    .batch_i   (batch_q),
    .cfg_clr_i (cfg_ok),
    .fwd_vld_i, .fwd_data_i, .fwd_last_i,
    .out_vld_o, .out_data_o, .out_rdy_i,
    .rev_vld_o, .rev_req_o, .rev_cnt_o,
    .idle_o    (c_idle)
  );

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !quiet |=> $stable(mode_q) && $stable(batch_q)) else $error("config moved while busy"); // R8
endmodule

// File: tb/credit_stream_channel_bench.sv
`timescale 1ns/1ps
module credit_stream_channel_bench;
  localparam int W    = 8;
  localparam int PDEP = 4;
  localparam int CDEP = 4;
  localparam int CCW  = $clog2(CDEP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [CCW-1:0] cfg_batch = '0;
  logic [1:0] mode;
  logic [CCW-1:0] batch;
  logic in_vld = 1'b0, in_rdy, out_vld, out_rdy = 1'b0;
  logic [W-1:0] in_data = '0, out_data;
  logic fwd_vld, fwd_last, rev_vld, rev_req;
  logic [W-1:0] fwd_data;
  logic [CCW-1:0] rev_cnt;

  int vectors = 0, fails = 0, cyc = 0;
  int occ = 0, prev_occ = 0, cr_sum = 0, cr_msgs = 0, fwd_total = 0;
  int cap = 0, burst = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  credit_stream_channel #(.W(W), .PDEP(PDEP), .CDEP(CDEP)) u_credit_stream_channel (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode), .cfg_batch_i(cfg_batch),
    .mode_o(mode), .batch_o(batch),
    .in_vld_i(in_vld), .in_data_i(in_data), .in_rdy_o(in_rdy),
    .fwd_vld_o(fwd_vld), .fwd_data_o(fwd_data), .fwd_last_o(fwd_last),
    .fwd_vld_i(fwd_vld), .fwd_data_i(fwd_data), .fwd_last_i(fwd_last),
    .rev_vld_o(rev_vld), .rev_req_o(rev_req), .rev_cnt_o(rev_cnt),
    .rev_vld_i(rev_vld), .rev_req_i(rev_req), .rev_cnt_i(rev_cnt),
    .out_vld_o(out_vld), .out_data_o(out_data), .out_rdy_i(out_rdy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  function automatic logic pv(input int p);
    case (p)
      0: return 1'b1;
      1: return (cyc % 2) == 0;
      2: return (cyc % 5) != 0;
      default: return ((cyc / 3) % 2) == 0;
    endcase
  endfunction

  function automatic logic cr(input int p);
    case (p)
      0: return 1'b1;
      1: return (cyc % 3) != 0;
      2: return (cyc % 4) == 0;
      default: return ((cyc / 7) % 2) == 1;
    endcase
  endfunction

  // link monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rev_vld && !rev_req) begin
        cr_sum += int'(rev_cnt);
        cr_msgs++;
        if (mode == 2'd0) chk(rev_cnt == 1, "R4 credit count", int'(rev_cnt), 1);
        if (mode == 2'd1) begin
          chk(rev_cnt >= 1 && rev_cnt <= batch, "R5 credit range", int'(rev_cnt), int'(batch));
          if (rev_cnt < batch) chk(out_vld == 1'b0, "R5 flush only on drain", int'(out_vld), 0);
        end
      end
      if (rev_vld && rev_req) begin
        chk(mode == 2'd2, "R6 request mode", int'(mode), 2);
        chk(int'(rev_cnt) == CDEP - prev_occ, "R6 request size", int'(rev_cnt), CDEP - prev_occ);
        cap = int'(rev_cnt);
        burst = 0;
      end
      if (fwd_vld) begin
        fwd_total++;
        if (mode == 2'd2) begin
          burst++;
          if (fwd_last) chk(burst <= cap, "R6 burst cap", burst, cap);
        end
      end
      prev_occ = occ;
      occ = occ + int'(fwd_vld) - int'(out_vld && out_rdy);
      if (fwd_vld) chk(occ <= CDEP, "R3 remote occupancy", occ, CDEP);
    end
  end

  task automatic cfg(input int m, input int n, input int exp_m, input int exp_n);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_mode = 2'(m); cfg_batch = CCW'(n);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    @(negedge clk);
    chk(int'(mode) == exp_m, "R8 mode", int'(mode), exp_m);
    chk(int'(batch) == exp_n, "R8 batch", int'(batch), exp_n);
  endtask

  task automatic settle();
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_stream(input int p, input int n, input int sid);
    cr_sum = 0; cr_msgs = 0;
    fork
      begin
        int i = 0;
        while (i < n) begin
          @(posedge clk); #1;
          in_vld = pv(p); in_data = W'(sid * 37 + i);
          @(negedge clk);
          if (in_vld && in_rdy) i++;
        end
        @(posedge clk); #1 in_vld = 1'b0;
      end
      begin
        int j = 0;
        while (j < n) begin
          @(posedge clk); #1;
          out_rdy = cr(p);
          @(negedge clk);
          if (out_vld && out_rdy) begin
            chk(out_data == W'(sid * 37 + j), "R1 data order", int'(out_data), (sid * 37 + j) % 256);
            j++;
          end
        end
        @(posedge clk); #1 out_rdy = 1'b0;
      end
    join
    settle();
    chk(out_vld == 1'b0, "R2 empty after drain", int'(out_vld), 0);
    if (mode != 2'd2) chk(cr_sum == n, "R4 R5 credit sum", cr_sum, n);
    if (mode == 2'd0) chk(cr_msgs == n, "R4 message per pop", cr_msgs, n);
  endtask

  task automatic block_test(input int base, input bit try_cfg);
    int acc = 0;
    fwd_total = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      in_vld = 1'b1; in_data = W'(base + acc);
      @(negedge clk);
      if (in_rdy) acc++;
    end
    @(posedge clk); #1 in_vld = 1'b0;
    @(negedge clk);
    chk(acc == CDEP + PDEP, "R3 accepted while stalled", acc, CDEP + PDEP);
    chk(in_rdy == 1'b0, "R3 input blocked", int'(in_rdy), 0);
    chk(fwd_total == CDEP, "R7 initial credit", fwd_total, CDEP);
    if (try_cfg) cfg(1, 2, int'(mode), int'(batch));
    begin
      int j = 0;
      while (j < acc) begin
        @(posedge clk); #1 out_rdy = 1'b1;
        @(negedge clk);
        if (out_vld && out_rdy) begin
          chk(out_data == W'(base + j), "R1 drain order", int'(out_data), (base + j) % 256);
          j++;
        end
      end
      @(posedge clk); #1 out_rdy = 1'b0;
    end
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    int sid = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_rdy == 1'b1, "R7 reset in_rdy", int'(in_rdy), 1);
    chk(out_vld == 1'b0, "R7 reset out_vld", int'(out_vld), 0);
    chk(fwd_vld == 1'b0 && rev_vld == 1'b0, "R7 reset link", int'(fwd_vld | rev_vld), 0);
    chk(mode == 2'd0, "R7 reset mode", int'(mode), 0);
    chk(int'(batch) == CDEP, "R7 reset batch", int'(batch), CDEP);

    block_test(100, 1'b1);

    cfg(3, 2, 0, CDEP);
    cfg(1, 0, 0, CDEP);
    cfg(1, CDEP + 1, 0, CDEP);
    cfg(1, 2, 1, 2);
    cfg(0, CDEP, 0, CDEP);

    for (int m = 0; m < 3; m++) begin
      for (int n = 1; n <= CDEP; n++) begin
        if (m != 1 && n != CDEP) continue;
        cfg(m, n, m, n);
        for (int p = 0; p < 4; p++) begin
          run_stream(p, 20, sid);
          sid++;
        end
      end
    end

    block_test(200, 1'b1);

    report();
    $finish;
  end
endmodule